// File: doc/BRIEF.md
# Collision Heartbeat Generator

This block produces the signal-quality-error heartbeat for a 10 Mb/s twisted-pair PHY. It watches the transmit enable from the MAC. When a frame ends, it waits a fixed number of clock cycles and then raises the collision line for a fixed number of cycles. This tells the MAC that the collision detection path is working. The block also passes a real collision indication from the line receiver straight through to the same collision output.

The heartbeat is withheld in four cases: a real collision was seen during the frame, the PHY is in repeater mode, the heartbeat is disabled by a control bit, or the link runs at 100 Mb/s. A new frame that starts while a heartbeat is still pending or active cancels that heartbeat. The delay and the pulse width are parameters in clock cycles. At a 25 MHz clock, 25 cycles gives about 1 µs.

Top module: `sqe_heartbeat`

## Requirements
- R1: After reset, with `lineCol` low and `txEn` low, `colOut` is low.
- R2: When `txEn` goes from high to low with `speed10`=1, `repeaterMode`=0 and `hbDisable`=0, and no collision was seen, the heartbeat starts after a delay. Let edge k be the first rising clock edge that samples `txEn` low after it was sampled high. The heartbeat part of `colOut` rises after edge k+DELAY.
- R3: The heartbeat stays high for exactly WIDTH clock cycles and then falls after edge k+DELAY+WIDTH.
- R4: If `lineCol` is sampled high on any edge that also samples `txEn` high during a frame, no heartbeat follows that frame.
- R5: The collision history is cleared on the edge that samples `txEn` rising. A clean frame that follows a frame with a collision gets a normal heartbeat.
- R6: `repeaterMode`=1 at the fall of `txEn` suppresses the heartbeat. `repeaterMode`=1 during a pending or active heartbeat ends it at the next edge.
- R7: `hbDisable`=1 suppresses the heartbeat.
- R8: `speed10`=0 (100 Mb/s) never produces a heartbeat.
- R9: If `txEn` is sampled high while a heartbeat is pending or active, the heartbeat is cancelled at that edge and does not resume.
- R10: `colOut` is the combinational OR of `lineCol` and the heartbeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Transmit enable from the MAC |
| lineCol | input | 1 | Real collision indication from the line |
| speed10 | input | 1 | 1 = 10 Mb/s mode, 0 = 100 Mb/s mode |
| repeaterMode | input | 1 | 1 = repeater mode, heartbeat forced off |
| hbDisable | input | 1 | 1 = heartbeat disabled |
| colOut | output | 1 | Collision output to the MAC |

## Verification
The hardest case to reach from the ports is a change that arrives part-way through a heartbeat. Examples are `txEn` rising, or repeater mode being set, after the delay has run but before the pulse has ended. The bench counts negative edges from the fall of `txEn` and injects the change at a chosen offset inside the pulse window. It then checks that `colOut` drops one cycle later and stays low. A second sequence runs a frame with a collision and then a clean frame. This shows that the collision history really is cleared when the next frame starts.

// File: rtl/sqe_hb_pkg.sv
package sqe_hb_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hbState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } hbStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic txFall;
    logic colSeen;
    logic hitDelay;
    logic hitWidth;
  } hbStatus_t;

endpackage

// File: rtl/sqe_hb_dp.sv
module sqe_hb_dp
  import sqe_hb_pkg::*;
#(
  parameter int DELAY = 25,
  parameter int WIDTH = 25
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEn,
  input  logic      lineCol,
  input  hbStrobe_t strobe,
  output hbStatus_t status
);
  localparam int MAXC  = (DELAY > WIDTH) ? DELAY : WIDTH;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic             txEnQ;
  logic             colSeen;
  logic [CNT_W-1:0] cnt;
  logic             txRise;

  assign txRise = txEn & ~txEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnQ   <= 1'b0;
      colSeen <= 1'b0;
      cnt     <= '0;
    end else begin
      txEnQ <= txEn;
      if (txRise)
        colSeen <= lineCol;
      else if (txEn && lineCol)
        colSeen <= 1'b1;
      if (strobe.cntClr)
        cnt <= '0;
      else if (strobe.cntInc)
        cnt <= cnt + 1'b1;
    end
  end

  assign status.txFall   = txEnQ & ~txEn;
  assign status.colSeen  = colSeen;
  assign status.hitDelay = (cnt == CNT_W'(DELAY - 1));
  assign status.hitWidth = (cnt == CNT_W'(WIDTH - 1));

  // R5
  col_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !txEnQ) |=> (colSeen == $past(lineCol)));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(MAXC));

endmodule

// File: rtl/sqe_hb_ctrl.sv
module sqe_hb_ctrl
  import sqe_hb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEn,
  input  logic      speed10,
  input  logic      repeaterMode,
  input  logic      hbDisable,
  input  hbStatus_t status,
  output hbStrobe_t strobe,
  output logic      hbPulse
);
  hbState_e state, stateNext;
  logic     gateOk;

  assign gateOk = speed10 & ~repeaterMode & ~hbDisable;

  always_comb begin
    stateNext     = state;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    unique case (state)
      HB_IDLE: begin
        if (status.txFall && gateOk && !status.colSeen) begin
          stateNext     = HB_WAIT;
          strobe.cntClr = 1'b1;
        end
      end
      HB_WAIT: begin
        if (txEn || !gateOk) begin
          stateNext     = HB_IDLE;
          strobe.cntClr = 1'b1;
        end else if (status.hitDelay) begin
          stateNext     = HB_PULSE;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      HB_PULSE: begin
        if (txEn || !gateOk || status.hitWidth) begin
          stateNext     = HB_IDLE;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: begin
        stateNext     = HB_IDLE;
        strobe.cntClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= HB_IDLE;
    else       state <= stateNext;
  end

  assign hbPulse = (state == HB_PULSE);

  // R6 R7 R8
  hb_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hbPulse) |-> $past(speed10 && !repeaterMode && !hbDisable));

  // R9
  tx_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && state != HB_IDLE) |=> !hbPulse);

  // R2
  no_rise_in_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hbPulse) |-> !$past(txEn));

endmodule

// File: rtl/sqe_heartbeat.sv
module sqe_heartbeat
  import sqe_hb_pkg::*;
#(
  parameter int DELAY = 25,
  parameter int WIDTH = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic txEn,
  input  logic lineCol,
  input  logic speed10,
  input  logic repeaterMode,
  input  logic hbDisable,
  output logic colOut
);
  hbStrobe_t strobe;
  hbStatus_t status;
  logic      hbPulse;

  sqe_hb_dp #(.DELAY(DELAY), .WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .txEn   (txEn),
    .lineCol(lineCol),
    .strobe (strobe),
    .status (status)
  );

  sqe_hb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txEn        (txEn),
    .speed10     (speed10),
    .repeaterMode(repeaterMode),
    .hbDisable   (hbDisable),
    .status      (status),
    .strobe      (strobe),
    .hbPulse     (hbPulse)
  );

  assign colOut = lineCol | hbPulse;

  // R10
  col_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineCol |-> colOut);

endmodule

// File: tb/sqe_heartbeat_bench.sv
module sqe_heartbeat_bench;
  localparam int D = 25;
  localparam int W = 25;

  logic clk = 1'b0;
  logic rstN, txEn, lineCol, speed10, repeaterMode, hbDisable;
  logic colOut;
  int   nChecks = 0;
  int   nErrors = 0;

  always #5 clk = ~clk;

  sqe_heartbeat #(.DELAY(D), .WIDTH(W)) u_sqe_heartbeat (
    .clk(clk), .rstN(rstN), .txEn(txEn), .lineCol(lineCol),
    .speed10(speed10), .repeaterMode(repeaterMode),
    .hbDisable(hbDisable), .colOut(colOut)
  );

  // vector: [12:5] frame length, [4] speed10, [3] repeater, [2] disable,
  //         [1] collision in frame, [0] heartbeat expected
  localparam logic [12:0] VEC [7] = '{
    {8'd6,  5'b10001},   // R2 R3 plain
    {8'd6,  5'b00000},   // R8 100 Mb/s
    {8'd6,  5'b11000},   // R6 repeater
    {8'd6,  5'b10100},   // R7 disabled
    {8'd8,  5'b10010},   // R4 collision
    {8'd40, 5'b10001},   // R5 clean frame after collision
    {8'd1,  5'b10001}    // R2 one-cycle frame
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a frame, end it, then record first high offset and high count
  task automatic runFrame(input int len, input bit col, output int first, output int count);
    @(negedge clk) txEn = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (col && i == len / 2) lineCol = 1'b1;
      @(negedge clk) lineCol = 1'b0;
    end
    txEn = 1'b0;
    first = -1;
    count = 0;
    for (int i = 1; i <= D + W + 6; i++) begin
      @(negedge clk);
      if (colOut) begin
        if (first < 0) first = i;
        count++;
      end
    end
  endtask

  initial begin
    int first, count;
    int ctr;
    bit wasHigh;
    rstN = 1'b0; txEn = 1'b0; lineCol = 1'b0;
    speed10 = 1'b1; repeaterMode = 1'b0; hbDisable = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(colOut == 1'b0, "R1 reset", colOut, 0);

    for (int v = 0; v < 7; v++) begin
      speed10 = VEC[v][4]; repeaterMode = VEC[v][3]; hbDisable = VEC[v][2];
      runFrame(int'(VEC[v][12:5]), VEC[v][1], first, count);
      if (VEC[v][0]) begin
        check(first == D + 1, "R2 delay", first, D + 1);
        check(count == W, "R3 width", count, W);
      end else begin
        check(count == 0, "R4/R6/R7/R8 suppressed", count, 0);
      end
    end
    speed10 = 1'b1; repeaterMode = 1'b0; hbDisable = 1'b0;

    // R10 pass-through while idle
    @(negedge clk) lineCol = 1'b1;
    #1 check(colOut == 1'b1, "R10 line collision", colOut, 1);
    @(negedge clk) lineCol = 1'b0;
    #1 check(colOut == 1'b0, "R10 release", colOut, 0);

    // R9 cancel during active pulse
    @(negedge clk) txEn = 1'b1;
    repeat (4) @(negedge clk);
    txEn = 1'b0;
    repeat (D + 3) @(negedge clk);
    wasHigh = colOut;
    check(wasHigh, "R9 pulse active", colOut, 1);
    txEn = 1'b1;
    @(negedge clk);
    check(colOut == 1'b0, "R9 cancel in pulse", colOut, 0);
    ctr = 0;
    for (int i = 0; i < D + W; i++) begin
      @(negedge clk);
      if (colOut) ctr++;
    end
    check(ctr == 0, "R9 no resume", ctr, 0);

    // R9 cancel during wait, then next frame gets full heartbeat
    txEn = 1'b0;
    repeat (3) @(negedge clk);
    txEn = 1'b1;
    ctr = 0;
    for (int i = 0; i < D + W; i++) begin
      @(negedge clk);
      if (colOut) ctr++;
    end
    check(ctr == 0, "R9 cancel in wait", ctr, 0);
    txEn = 1'b0;
    first = -1; count = 0;
    for (int i = 1; i <= D + W + 6; i++) begin
      @(negedge clk);
      if (colOut) begin
        if (first < 0) first = i;
        count++;
      end
    end
    check(first == D + 1, "R9 fresh delay", first, D + 1);

    // R6 repeater set mid-pulse ends it next cycle
    @(negedge clk) txEn = 1'b1;
    @(negedge clk) txEn = 1'b0;
    repeat (D + 2) @(negedge clk);
    check(colOut == 1'b1, "R6 pulse before repeater", colOut, 1);
    repeaterMode = 1'b1;
    @(negedge clk);
    check(colOut == 1'b0, "R6 repeater cancels", colOut, 0);
    repeaterMode = 1'b0;
    ctr = 0;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (colOut) ctr++;
    end
    check(ctr == 0, "R6 stays off", ctr, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule